// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits on the active-low chip-enable path between a host and one or two battery-backed static RAMs. While the supply is good, it passes the host enable through to the memories. When the supply-good comparator flag falls, the block write-protects the memories by forcing the conditioned enable inactive (high). An access that has already reached the memory may finish, but only within a bounded grace window.

When power returns, the enable is held inactive for a recovery interval before host accesses pass again. A second comparator flag selects the memory supply: main or battery. A strap input chooses between two deselect thresholds, and the block reports which one is in use.

All comparator flags, the strap and the host enable cross into the clock domain through two-flop synchronizers. The grace window (`GRACE_CYC`) and the recovery hold (`RECOV_CYC`) are clock-cycle counts. They are set per clock rate so that they give the required time (a 40 µs minimum window, a 40 to 200 ms hold).

Top module: `pf_ce_gate`

## Requirements
- R1: While the supply is good and no hold is running, `ce_no` equals `host_ce_ni` as it was three rising clock edges earlier.
- R2: When `vcc_good_i` falls while `ce_no` is high, `ce_no` stays high whatever `host_ce_ni` does, including a host enable that falls in the same cycle as the power-fail flag.
- R3: When `vcc_good_i` falls while `ce_no` is low and the host still asserts enable, `ce_no` stays low until the host releases it. It is forced high no later than `GRACE_CYC`+3 rising edges after the flag falls.
- R4: After `vcc_good_i` rises, `ce_no` is held high and `host_ce_ni` is ignored. With the host enable held low, `ce_no` falls exactly `RECOV_CYC`+3 rising edges after the rise.
- R5: A fall of `vcc_good_i` during the recovery hold aborts the hold. The full hold restarts from the next rise.
- R6: `batt_sel_o` is 1 (battery supply) when `vcc_above_sw_i` is 0 and 0 (main supply) when it is 1, three rising edges after a change.
- R7: `prot_o` is 1 exactly while `ce_no` is held high by protection (protected or recovery hold). It is 0 while the host enable passes through, including during the grace window.
- R8: `thr_sel_o` reports the synchronized strap: 1 means the lower (alternate) threshold, 0 the upper. It reflects a change three rising edges later.
- R9: During reset `ce_no`=1, `prot_o`=1 and `batt_sel_o`=0. After reset the recovery hold runs as if power had just returned, so with supply good and the host enable low, `ce_no` falls at the `RECOV_CYC`-th rising edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_ce_ni | input | 1 | Host chip enable, active low |
| vcc_good_i | input | 1 | Comparator flag: supply above deselect threshold |
| vcc_above_sw_i | input | 1 | Comparator flag: supply above battery switchover level |
| thr_strap_i | input | 1 | Threshold select strap (1 = lower threshold) |
| ce_no | output | 1 | Conditioned chip enable to memories, active low |
| batt_sel_o | output | 1 | Supply source select, 1 = battery |
| prot_o | output | 1 | Output held inactive by protection |
| thr_sel_o | output | 1 | Threshold in use, 1 = lower |

## Verification
On every cycle, the assertions check four things. The enable stays high when protection is active. No access starts while the synchronized supply flag is low. The enable is never low for more than the grace bound after the flag drops. Every falling edge of the enable is preceded by at least the recovery hold of continuous good supply. The battery select is also checked against a stable switchover flag. Only the bench scenarios can show the following: the exact three-cycle latencies, the exact hold length after a mid-hold dip, early release inside the grace window, and the strap report.

// File: rtl/pf_ce_gate_pkg.sv
package pf_ce_gate_pkg;
  typedef enum logic [1:0] {
    ST_RECOV = 2'd0,
    ST_RUN   = 2'd1,
    ST_GRACE = 2'd2,
    ST_PROT  = 2'd3
  } gate_state_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int unsigned       W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pf_timer.sv
module pf_timer #(
  parameter int unsigned  CW      = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= RST_VAL;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pf_gate_fsm.sv
module pf_gate_fsm
  import pf_ce_gate_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 8,
  parameter int unsigned RECOV_CYC = 20,
  parameter int unsigned CW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ok_i,
  input  logic          host_ce_ni,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          tmr_dec_o,
  output logic          ce_no,
  output logic          prot_o
);
  localparam logic [CW-1:0] GRACE_LD = CW'(GRACE_CYC - 1);
  localparam logic [CW-1:0] RECOV_LD = CW'(RECOV_CYC - 1);

  gate_state_e st_q, st_d;
  logic ce_q, prot_q;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    tmr_dec_o  = 1'b0;
    unique case (st_q)
      ST_RECOV: begin
        if (!ok_i)           st_d = ST_PROT;
        else if (tmr_zero_i) st_d = ST_RUN;
        else                 tmr_dec_o = 1'b1;
      end
      ST_RUN: begin
        if (!ok_i) begin
          // only an access already on the output may continue
          if (!ce_q && !host_ce_ni) begin
            st_d       = ST_GRACE;
            tmr_load_o = 1'b1;
            tmr_val_o  = GRACE_LD;
          end else begin
            st_d = ST_PROT;
          end
        end
      end
      ST_GRACE: begin
        if (host_ce_ni || tmr_zero_i) st_d = ST_PROT;
        else                          tmr_dec_o = 1'b1;
      end
      ST_PROT: begin
        if (ok_i) begin
          st_d       = ST_RECOV;
          tmr_load_o = 1'b1;
          tmr_val_o  = RECOV_LD;
        end
      end
      default: st_d = ST_PROT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RECOV;
      ce_q   <= 1'b1;
      prot_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      ce_q   <= (st_d == ST_RUN || st_d == ST_GRACE) ? host_ce_ni : 1'b1;
      prot_q <= (st_d == ST_RECOV || st_d == ST_PROT);
    end
  end

  assign ce_no  = ce_q;
  assign prot_o = prot_q;
endmodule

// File: rtl/pf_ce_gate.sv
module pf_ce_gate #(
  parameter int unsigned GRACE_CYC = 8,
  parameter int unsigned RECOV_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_ce_ni,
  input  logic vcc_good_i,
  input  logic vcc_above_sw_i,
  input  logic thr_strap_i,
  output logic ce_no,
  output logic batt_sel_o,
  output logic prot_o,
  output logic thr_sel_o
);
  localparam int unsigned MAXC = (GRACE_CYC > RECOV_CYC) ? GRACE_CYC : RECOV_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned NSYN = 4;
  // sync order: {host_ce_n, ok, above_sw, strap}
  localparam logic [NSYN-1:0] SYN_RST = 4'b1110;

  logic [NSYN-1:0] syn_q;
  logic            s_ce_n, s_ok, s_sw, s_thr;
  logic            tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0]   tmr_val;
  logic            batt_q, thr_q;

  pf_sync #(.W(NSYN), .RST_VAL(SYN_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({host_ce_ni, vcc_good_i, vcc_above_sw_i, thr_strap_i}),
    .q_o    (syn_q)
  );

  assign {s_ce_n, s_ok, s_sw, s_thr} = syn_q;

  pf_timer #(.CW(CW), .RST_VAL(CW'(RECOV_CYC - 1))) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  pf_gate_fsm #(.GRACE_CYC(GRACE_CYC), .RECOV_CYC(RECOV_CYC), .CW(CW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ok_i       (s_ok),
    .host_ce_ni (s_ce_n),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_dec_o  (tmr_dec),
    .ce_no      (ce_no),
    .prot_o     (prot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      batt_q <= 1'b0;
      thr_q  <= 1'b0;
    end else begin
      batt_q <= ~s_sw;
      thr_q  <= s_thr;
    end
  end

  assign batt_sel_o = batt_q;
  assign thr_sel_o  = thr_q;
endmodule

// File: rtl/pf_ce_gate_chk.sv
module pf_ce_gate_chk #(
  parameter int unsigned GRACE_CYC = 8,
  parameter int unsigned RECOV_CYC = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic s_ok,
  input logic s_sw,
  input logic ce_no,
  input logic prot_o,
  input logic batt_sel_o
);
  localparam int unsigned GW = $clog2(GRACE_CYC + 3);
  localparam int unsigned RW = $clog2(RECOV_CYC + 2);

  logic [GW-1:0] low_cnt;
  logic [RW-1:0] ok_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      ok_run  <= '0;
    end else begin
      if (!ce_no && !s_ok) begin
        if (low_cnt != GW'(GRACE_CYC + 2)) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
      if (!s_ok) ok_run <= '0;
      else if (ok_run != RW'(RECOV_CYC)) ok_run <= ok_run + 1'b1;
    end
  end

  AST_PROT_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o |-> ce_no); // R7

  AST_NO_NEW_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_no) && !s_ok && !$past(s_ok)) |-> ce_no); // R2

  AST_GRACE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= GW'(GRACE_CYC + 1)); // R3

  AST_HOLD_BEFORE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_no) |-> (ok_run >= RW'(RECOV_CYC))); // R4

  AST_BATT_ON_LOW_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_sw && !$past(s_sw)) |-> batt_sel_o); // R6
endmodule

bind pf_ce_gate pf_ce_gate_chk #(.GRACE_CYC(GRACE_CYC), .RECOV_CYC(RECOV_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_ok       (s_ok),
  .s_sw       (s_sw),
  .ce_no      (ce_no),
  .prot_o     (prot_o),
  .batt_sel_o (batt_sel_o)
);

// File: tb/tb_pf_ce_gate.sv
module tb_pf_ce_gate;
  localparam int G = 8;
  localparam int R = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic host_ce_ni = 1'b0;
  logic vcc_good_i = 1'b1;
  logic vcc_above_sw_i = 1'b1;
  logic thr_strap_i = 1'b0;
  logic ce_no, batt_sel_o, prot_o, thr_sel_o;

  int errs = 0;
  int chks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pf_ce_gate #(.GRACE_CYC(G), .RECOV_CYC(R)) dut (
    .clk_i, .rst_ni, .host_ce_ni, .vcc_good_i, .vcc_above_sw_i, .thr_strap_i,
    .ce_no, .batt_sel_o, .prot_o, .thr_sel_o
  );

  task automatic check(input string req, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edges until the chosen output reaches val (0: ce_no, 1: batt_sel_o)
  task automatic edges_to(input int sel, input logic val, output int n);
    n = -1;
    for (int k = 1; k <= 1000; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if ((sel == 0 ? ce_no : batt_sel_o) == val) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic exp_delayed(input logic [2:0] hist);
    return hist[2];
  endfunction

  initial begin
    int n;
    logic [2:0] h_ce, h_sw;
    void'($urandom(32'd1234));

    // R9 reset state
    repeat (3) @(negedge clk_i);
    check("R9 ce in reset", ce_no, 1);
    check("R9 prot in reset", prot_o, 1);
    check("R9 batt in reset", batt_sel_o, 0);
    rst_ni = 1'b1;
    edges_to(0, 1'b0, n);
    check("R9 hold after reset", n, R);
    check("R7 prot low in run", prot_o, 0);

    // R1/R6 random pass-through
    h_ce = {3{host_ce_ni}};
    h_sw = {3{vcc_above_sw_i}};
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      check("R1 follow", ce_no, exp_delayed(h_ce));
      check("R6 supply select", batt_sel_o, !exp_delayed(h_sw));
      host_ce_ni     = 1'($urandom_range(0, 1));
      vcc_above_sw_i = ($urandom_range(0, 7) != 0);
      h_ce = {h_ce[1:0], host_ce_ni};
      h_sw = {h_sw[1:0], vcc_above_sw_i};
    end
    vcc_above_sw_i = 1'b1;
    host_ce_ni = 1'b1;
    idle(5);

    // R2 fail with new access in the same cycle
    host_ce_ni = 1'b0;
    vcc_good_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check("R2 no new access", ce_no, 1);
    end
    check("R7 prot in protect", prot_o, 1);
    host_ce_ni = 1'b1; idle(3); host_ce_ni = 1'b0; idle(4);
    check("R2 host ignored", ce_no, 1);

    // R6 directed switchover
    vcc_above_sw_i = 1'b0;
    edges_to(1, 1'b1, n);
    check("R6 to battery latency", n, 3);
    vcc_above_sw_i = 1'b1;
    edges_to(1, 1'b0, n);
    check("R6 to main latency", n, 3);

    // R5 dip during hold, then full R4 hold
    vcc_good_i = 1'b1;
    idle(R / 2);
    check("R4 held during recovery", ce_no, 1);
    vcc_good_i = 1'b0;
    idle(5);
    check("R5 still held after dip", ce_no, 1);
    vcc_good_i = 1'b1;
    edges_to(0, 1'b0, n);
    check("R5 hold restarts", n, R + 3);
    check("R4 prot released", prot_o, 0);

    // R3 grace timeout
    idle(4);
    vcc_good_i = 1'b0;
    edges_to(0, 1'b1, n);
    check("R3 grace timeout", n, G + 3);
    check("R7 prot after timeout", prot_o, 1);

    // R3 early release within grace
    vcc_good_i = 1'b1;
    idle(R + 10);
    check("R4 access passes after hold", ce_no, 0);
    vcc_good_i = 1'b0;
    idle(4);
    check("R3 access continues", ce_no, 0);
    check("R7 prot low in grace", prot_o, 0);
    host_ce_ni = 1'b1;
    edges_to(0, 1'b1, n);
    check("R3 release latency", n, 3);
    host_ce_ni = 1'b0;
    idle(6);
    check("R2 blocked after release", ce_no, 1);

    // R8 strap report
    thr_strap_i = 1'b1;
    idle(3);
    check("R8 lower threshold", thr_sel_o, 1);
    thr_strap_i = 1'b0;
    idle(3);
    check("R8 upper threshold", thr_sel_o, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errs++;
      chks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule